// File: doc/BRIEF.md
# Dual-Bus Micro-Operation Sequencer

This block pairs a hardwired control sequencer with the datapath of a small general-register machine. All register sources sit on one internal bus, the source side. All latching destinations load from a second bus, the destination side. A single gate joins the two buses. Because of this layout, every register transfer needs three signals in the same beat: the source's output enable, the gate, and the destination's input enable.

The sequencer steps through a fixed chain of beats:

- It fetches an instruction from an external word memory. The memory's read data is combinational on the current address.
- It decodes the opcode.
- For an add or subtract, it latches the two operands into the ALU input latches X and Y, one per beat.
- It writes the ALU result back into the destination register.

The control word of every beat is brought out as a port, so the exact micro-operation sequence can be observed as well as the register contents.

Instruction word (16-bit default): opcode in bits [15:12], destination register in bits [11:10], source register in bits [9:8], bits [7:0] unused. Opcode 0001 adds and opcode 0010 subtracts. Registers R0..R3 come out of reset at INIT_BASE + i*INIT_STEP.

Control word bit positions:

| Bit | Signal | Meaning |
|-----|--------|---------|
| 15 | pc_out | PC drives the source bus |
| 14 | dr_out | Data buffer drives the source bus |
| 13 | reg_out | Selected register drives the source bus |
| 12 | alu_out | ALU result drives the source bus |
| 11 | gate | Joins the source bus to the destination bus |
| 10 | ar_in | Address register loads |
| 9 | dr_in | Data buffer loads from memory |
| 8 | ir_in | Instruction register loads |
| 7 | x_in | Latch X loads |
| 6 | y_in | Latch Y loads |
| 5 | reg_in | Selected register loads |
| 4 | pc_inc | PC increments |
| 3 | mem_rw | Memory read cycle |
| 2 | alu_sub | ALU subtracts (otherwise adds) |
| [1:0] | reg_sel | Register index |

Top module: `dbus_core`

## Requirements
- R1: After reset, PC and the address register are 0, R0..R3 hold INIT_BASE + i*INIT_STEP, and the first beat is the address beat (beat 0).
- R2: Beat 0 issues control word 16'h8C00 (pc_out, gate, ar_in). From the next beat on, mem_addr equals the PC value of beat 0.
- R3: Beat 1 issues 16'h0218 (dr_in, pc_inc, mem_rw). The data buffer captures mem_rdata, and the PC advances by one, wrapping modulo 2^ADDR_W.
- R4: Beat 2 issues 16'h4900 (dr_out, gate, ir_in), and the instruction register takes the data buffer value.
- R5: Beat 3 (decode) issues 16'h0000. When the opcode is neither 0001 nor 0010, the next beat is beat 0 and no register R0..R3 changes.
- R6: For opcode 0001, beats 4, 5 and 6 issue 16'h2880|dst, 16'h2840|src and 16'h1820|dst. After beat 6, R[dst] = R[dst] + R[src] modulo 2^WORD_W, and beat 0 follows.
- R7: For opcode 0010, the same beats issue the same words, except that beat 6 also sets alu_sub (16'h1824|dst). After beat 6, R[dst] = R[dst] - R[src] modulo 2^WORD_W.
- R8: In every beat at most one of pc_out, dr_out, reg_out and alu_out is set, and any beat that loads a destination from a bus also sets the gate.
- R9: When the source and destination fields are equal, ADD leaves twice the old value and SUB leaves zero in that register.
- R10: mem_rw is set in beat 1 and in no other beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | WORD_W | Memory word at mem_addr |
| mem_addr | output | ADDR_W | Address register contents |
| mem_rw | output | 1 | Memory read strobe for the current beat |
| ctl_word | output | 16 | Control word of the current beat |
| reg_flat | output | 4*WORD_W | R0..R3 packed, R0 in the low bits |

## Verification
The bench builds the block with its defaults: a 16-bit word, an 8-bit address, a base of 16'h1357 and a step of 16'h2222. With an 8-bit address, a program of a few hundred words carries the PC through its wrap from 255 to 0 within the run. The chosen base and step drive additions past 2^16 and subtractions below zero within the first dozen instructions. The program mixes add, subtract, two non-arithmetic opcodes and equal source/destination fields, so short and long beat chains interleave. The reference model predicts the control word, address, read strobe and registers on every beat.

// File: rtl/dbus_pkg.sv
package dbus_pkg;

    localparam int NREG      = 4;
    localparam int REG_SEL_W = $clog2(NREG);
    localparam int OPC_W     = 4;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_SUB = 4'b0010;

    typedef enum logic [2:0] {
        BT_ADDR   = 3'd0,
        BT_READ   = 3'd1,
        BT_LOADIR = 3'd2,
        BT_DECODE = 3'd3,
        BT_OPX    = 3'd4,
        BT_OPY    = 3'd5,
        BT_WB     = 3'd6
    } beat_e;

    typedef struct packed {
        logic                 pc_out;
        logic                 dr_out;
        logic                 reg_out;
        logic                 alu_out;
        logic                 gate;
        logic                 ar_in;
        logic                 dr_in;
        logic                 ir_in;
        logic                 x_in;
        logic                 y_in;
        logic                 reg_in;
        logic                 pc_inc;
        logic                 mem_rw;
        logic                 alu_sub;
        logic [REG_SEL_W-1:0] reg_sel;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic is_alu_op(input logic [OPC_W-1:0] op);
        return (op == OPC_ADD) || (op == OPC_SUB);
    endfunction

    function automatic logic any_driver(input ctl_t c);
        return c.pc_out | c.dr_out | c.reg_out | c.alu_out;
    endfunction

    function automatic logic any_bus_load(input ctl_t c);
        return c.ar_in | c.ir_in | c.x_in | c.y_in | c.reg_in;
    endfunction

endpackage

// File: rtl/dbus_sequencer.sv
module dbus_sequencer
    import dbus_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [OPC_W-1:0]       opcode,
    input  logic [REG_SEL_W-1:0]   dst_sel,
    input  logic [REG_SEL_W-1:0]   src_sel,
    output ctl_t                   ctl,
    output beat_e                  beat
);

    beat_e beat_q;
    assign beat = beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= BT_ADDR;
        end else begin
            case (beat_q)
                BT_DECODE: beat_q <= is_alu_op(opcode) ? BT_OPX : BT_ADDR;
                BT_WB:     beat_q <= BT_ADDR;
                default:   beat_q <= beat_e'(beat_q + 3'd1);
            endcase
        end
    end

    always_comb begin
        ctl = '0;
        case (beat_q)
            BT_ADDR: begin
                ctl.pc_out = 1'b1;
                ctl.gate   = 1'b1;
                ctl.ar_in  = 1'b1;
            end
            BT_READ: begin
                ctl.mem_rw = 1'b1;
                ctl.dr_in  = 1'b1;
                ctl.pc_inc = 1'b1;
            end
            BT_LOADIR: begin
                ctl.dr_out = 1'b1;
                ctl.gate   = 1'b1;
                ctl.ir_in  = 1'b1;
            end
            BT_OPX: begin
                ctl.reg_out = 1'b1;
                ctl.gate    = 1'b1;
                ctl.x_in    = 1'b1;
                ctl.reg_sel = dst_sel;
            end
            BT_OPY: begin
                ctl.reg_out = 1'b1;
                ctl.gate    = 1'b1;
                ctl.y_in    = 1'b1;
                ctl.reg_sel = src_sel;
            end
            BT_WB: begin
                ctl.alu_out = 1'b1;
                ctl.gate    = 1'b1;
                ctl.reg_in  = 1'b1;
                ctl.alu_sub = (opcode == OPC_SUB);
                ctl.reg_sel = dst_sel;
            end
            default: ctl = '0;
        endcase
    end

    assert_one_driver_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.pc_out, ctl.dr_out, ctl.reg_out, ctl.alu_out}));

    assert_gate_on_transfer_R8: assert property (@(posedge clk) disable iff (rst)
        (any_driver(ctl) && any_bus_load(ctl)) |-> ctl.gate);

    assert_read_beat_only_R10: assert property (@(posedge clk) disable iff (rst)
        ctl.mem_rw |-> (beat_q == BT_READ));

    assert_nonalu_returns_R5: assert property (@(posedge clk) disable iff (rst)
        (beat_q == BT_DECODE && !is_alu_op(opcode)) |=> (beat_q == BT_ADDR));

    assert_wb_then_fetch_R6: assert property (@(posedge clk) disable iff (rst)
        (beat_q == BT_WB) |=> (beat_q == BT_ADDR));

endmodule

// File: rtl/dbus_regfile.sv
module dbus_regfile
    import dbus_pkg::*;
#(
    parameter int             W         = 16,
    parameter logic [W-1:0]   INIT_BASE = '0,
    parameter logic [W-1:0]   INIT_STEP = '0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [REG_SEL_W-1:0]   wsel,
    input  logic [W-1:0]           wdata,
    input  logic [REG_SEL_W-1:0]   rsel,
    output logic [W-1:0]           rdata,
    output logic [NREG*W-1:0]      flat
);

    logic [W-1:0] regs_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [W-1:0] RST_VAL = INIT_BASE + INIT_STEP * W'(i);

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= RST_VAL;
            end else if (we && (wsel == REG_SEL_W'(i))) begin
                regs_q[i] <= wdata;
            end
        end

        assign flat[i*W +: W] = regs_q[i];

        assert_untouched_hold_R5: assert property (@(posedge clk) disable iff (rst)
            !(we && (wsel == REG_SEL_W'(i))) |=> $stable(regs_q[i]));
    end

    assign rdata = regs_q[rsel];

endmodule

// File: rtl/dbus_datapath.sv
module dbus_datapath
    import dbus_pkg::*;
#(
    parameter int             W         = 16,
    parameter int             AW        = 8,
    parameter logic [W-1:0]   INIT_BASE = '0,
    parameter logic [W-1:0]   INIT_STEP = '0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  ctl_t                   ctl,
    input  logic [W-1:0]           mem_rdata,
    output logic [AW-1:0]          mem_addr,
    output logic [OPC_W-1:0]       opcode,
    output logic [REG_SEL_W-1:0]   dst_sel,
    output logic [REG_SEL_W-1:0]   src_sel,
    output logic [NREG*W-1:0]      reg_flat
);

    localparam int OPC_LSB = W - OPC_W;
    localparam int DST_LSB = OPC_LSB - REG_SEL_W;
    localparam int SRC_LSB = DST_LSB - REG_SEL_W;

    logic [AW-1:0] pc_q, ar_q;
    logic [W-1:0]  dr_q, ir_q, x_q, y_q;
    logic [W-1:0]  rf_rdata, alu_res;
    logic [W-1:0]  bus_src, bus_dst;

    // source-side bus: exactly one driver selected by the control word
    always_comb begin
        bus_src = '0;
        if (ctl.pc_out)  bus_src = W'(pc_q);
        if (ctl.dr_out)  bus_src = dr_q;
        if (ctl.reg_out) bus_src = rf_rdata;
        if (ctl.alu_out) bus_src = alu_res;
    end

    // gate joining the two buses
    assign bus_dst = ctl.gate ? bus_src : '0;

    assign alu_res = ctl.alu_sub ? (x_q - y_q) : (x_q + y_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            ar_q <= '0;
            dr_q <= '0;
            ir_q <= '0;
            x_q  <= '0;
            y_q  <= '0;
        end else begin
            if (ctl.pc_inc) pc_q <= pc_q + AW'(1);
            if (ctl.ar_in)  ar_q <= bus_dst[AW-1:0];
            if (ctl.dr_in)  dr_q <= mem_rdata;
            if (ctl.ir_in)  ir_q <= bus_dst;
            if (ctl.x_in)   x_q  <= bus_dst;
            if (ctl.y_in)   y_q  <= bus_dst;
        end
    end

    dbus_regfile #(
        .W         (W),
        .INIT_BASE (INIT_BASE),
        .INIT_STEP (INIT_STEP)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl.reg_in),
        .wsel  (ctl.reg_sel),
        .wdata (bus_dst),
        .rsel  (ctl.reg_sel),
        .rdata (rf_rdata),
        .flat  (reg_flat)
    );

    assign mem_addr = ar_q;
    assign opcode   = ir_q[OPC_LSB +: OPC_W];
    assign dst_sel  = ir_q[DST_LSB +: REG_SEL_W];
    assign src_sel  = ir_q[SRC_LSB +: REG_SEL_W];

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
        ctl.pc_inc |=> (pc_q == $past(pc_q) + AW'(1)));

    assert_ar_from_pc_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.ar_in |=> (ar_q == $past(pc_q)));

    assert_dr_from_mem_R3: assert property (@(posedge clk) disable iff (rst)
        ctl.dr_in |=> (dr_q == $past(mem_rdata)));

    assert_ir_from_dr_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.ir_in |=> (ir_q == $past(dr_q)));

    for (genvar i = 0; i < NREG; i++) begin : g_wbchk
        assert_wb_result_R6: assert property (@(posedge clk) disable iff (rst)
            (ctl.reg_in && ctl.reg_sel == REG_SEL_W'(i)) |=>
            (reg_flat[i*W +: W] == ($past(ctl.alu_sub) ? ($past(x_q) - $past(y_q))
                                                       : ($past(x_q) + $past(y_q)))));
    end

endmodule

// File: rtl/dbus_core.sv
module dbus_core
    import dbus_pkg::*;
#(
    parameter int                   WORD_W    = 16,
    parameter int                   ADDR_W    = 8,
    parameter logic [WORD_W-1:0]    INIT_BASE = 16'h1357,
    parameter logic [WORD_W-1:0]    INIT_STEP = 16'h2222
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [WORD_W-1:0]       mem_rdata,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_rw,
    output logic [CTL_W-1:0]        ctl_word,
    output logic [NREG*WORD_W-1:0]  reg_flat
);

    ctl_t                 ctl;
    beat_e                beat;
    logic [OPC_W-1:0]     opcode;
    logic [REG_SEL_W-1:0] dst_sel, src_sel;

    dbus_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .opcode  (opcode),
        .dst_sel (dst_sel),
        .src_sel (src_sel),
        .ctl     (ctl),
        .beat    (beat)
    );

    dbus_datapath #(
        .W         (WORD_W),
        .AW        (ADDR_W),
        .INIT_BASE (INIT_BASE),
        .INIT_STEP (INIT_STEP)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .opcode    (opcode),
        .dst_sel   (dst_sel),
        .src_sel   (src_sel),
        .reg_flat  (reg_flat)
    );

    assign ctl_word = ctl;
    assign mem_rw   = ctl.mem_rw;

    assert_reset_fetch_R1: assert property (@(posedge clk)
        $fell(rst) |-> (beat == BT_ADDR && mem_addr == '0));

endmodule

// File: tb/tb_dbus_core.sv
module tb_dbus_core;

    localparam int            W     = 16;
    localparam int            AW    = 8;
    localparam logic [W-1:0]  BASE  = 16'h1357;
    localparam logic [W-1:0]  STEP  = 16'h2222;
    localparam int            DEPTH = 1 << AW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [W-1:0]      mem_rdata;
    logic [AW-1:0]     mem_addr;
    logic              mem_rw;
    logic [15:0]       ctl_word;
    logic [4*W-1:0]    reg_flat;

    logic [W-1:0] mem [DEPTH];

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    int           m_beat;
    logic [AW-1:0] m_pc, m_ar;
    logic [W-1:0]  m_dr, m_ir;
    logic [W-1:0]  m_r [4];
    string         reg_tag;

    always #2 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    dbus_core dut (
        .clk       (clk),
        .rst       (rst),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_rw    (mem_rw),
        .ctl_word  (ctl_word),
        .reg_flat  (reg_flat)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_ctl();
        logic [3:0] op  = m_ir[15:12];
        logic [1:0] dst = m_ir[11:10];
        logic [1:0] src = m_ir[9:8];
        case (m_beat)
            0: return 16'h8C00;
            1: return 16'h0218;
            2: return 16'h4900;
            3: return 16'h0000;
            4: return 16'h2880 | 16'(dst);
            5: return 16'h2840 | 16'(src);
            6: return 16'h1820 | ((op == 4'b0010) ? 16'h0004 : 16'h0000) | 16'(dst);
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic string ctl_tag();
        case (m_beat)
            0: return "R2 beat0";
            1: return "R3 beat1";
            2: return "R4 beat2";
            3: return "R5 decode";
            default: return (m_ir[15:12] == 4'b0010) ? "R7 sub beat" : "R6 add beat";
        endcase
    endfunction

    task automatic model_reset();
        m_beat = 0;
        m_pc   = '0;
        m_ar   = '0;
        m_dr   = '0;
        m_ir   = '0;
        for (int i = 0; i < 4; i++) m_r[i] = BASE + STEP * W'(i);
        reg_tag = "R1 reset regs";
    endtask

    task automatic model_step();
        logic [3:0] op  = m_ir[15:12];
        logic [1:0] dst = m_ir[11:10];
        logic [1:0] src = m_ir[9:8];
        case (m_beat)
            0: begin m_ar = m_pc; m_beat = 1; end
            1: begin m_dr = mem[m_ar]; m_pc = m_pc + 1'b1; m_beat = 2; end
            2: begin m_ir = m_dr; m_beat = 3; end
            3: begin
                if (m_ir[15:12] == 4'b0001 || m_ir[15:12] == 4'b0010) m_beat = 4;
                else begin m_beat = 0; reg_tag = "R5 nop regs"; end
            end
            4: m_beat = 5;
            5: m_beat = 6;
            6: begin
                if (op == 4'b0010) begin
                    m_r[dst] = m_r[dst] - m_r[src];
                    reg_tag = (src == dst) ? "R9 sub self" : "R7 sub result";
                end else begin
                    m_r[dst] = m_r[dst] + m_r[src];
                    reg_tag = (src == dst) ? "R9 add self" : "R6 add result";
                end
                m_beat = 0;
            end
            default: m_beat = 0;
        endcase
    endtask

    always @(negedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            check(ctl_tag(), 64'(ctl_word), 64'(exp_ctl()));
            check("R2 mem_addr", 64'(mem_addr), 64'(m_ar));
            check("R10 mem_rw", 64'(mem_rw), 64'(m_beat == 1));
            check(reg_tag, 64'(reg_flat), {m_r[3], m_r[2], m_r[1], m_r[0]});
            model_step();
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            logic [3:0] op;
            case (i % 5)
                0: op = 4'b0001;
                1: op = 4'b0010;
                2: op = 4'b0000;
                3: op = 4'b0001;
                default: op = 4'b1111;
            endcase
            mem[i] = {op, 2'((i * 3) % 4), 2'((i / 2) % 4), 8'(i)};
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (1800) @(posedge clk);
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule